// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Resolver with Vectored Acknowledge

This block joins two eight-line request resolvers into one fifteen-line interrupt source for a processor. The lower resolver (lines 0 to 7) talks to the processor. The upper resolver (lines 8 to 15) hangs off local line 2 of the lower one. Whenever the upper resolver holds any pending request, a one-shot mark is latched on lower line 2. The lower resolver therefore sees the whole upper group as one request with the priority of line 2. The outside request line 2 does not exist in this arrangement.

The processor sees a single interrupt line. To take an interrupt it pulses an acknowledge strobe for one clock. The block then clears the pending state of the winning line in the correct resolver, or in both resolvers when the upper group wins. One cycle later it presents an 8-bit vector with a one-cycle valid strobe. The upper five bits of the vector come from the base input of the resolver that answers. The lower three bits are the local line number, or 7 when the acknowledge finds nothing to serve.

Each line is configured separately as edge-sensitive or level-sensitive. Within each resolver, priority is fixed and the lowest local line number wins. Every pending request is served once per acknowledge, with no in-service nesting.

Top module: `irq_cascade_ack`

## Requirements
- R1: An edge-mode line becomes pending on a 0-to-1 change of its request input, sampled at a rising clock edge. An acknowledge clears it. A request held high after that does not make it pending again.
- R2: A level-mode line (its `lvl_i` bit is 1) is pending exactly while its request input is 1. Acknowledging it does not clear it.
- R3: Request bit n belongs to resolver n>>3, at local line n&7 (bits 0-7 lower, bits 8-15 upper). Within a resolver, the lowest-numbered pending local line wins. This includes lower line 2 standing in for the upper group.
- R4: `int_o` is 1 exactly when the lower resolver has a pending line. A request change sampled at a clock edge is visible on `int_o` right after that same edge.
- R5: After an acknowledge at edge t, `vec_vld_o` is 1 for exactly the cycle after t. When a lower line other than 2 wins, `vec_o` is {`mbase_i`[7:3], local line}.
- R6: Any pending request in the upper resolver latches lower line 2 at the same edge. Request bit 2 and its mode bit have no effect at all.
- R7: When lower line 2 wins and the upper resolver has a winner, both resolvers are acknowledged. `vec_o` is {`sbase_i`[7:3], upper local line}.
- R8: When lower line 2 wins and the upper resolver has nothing pending, `vec_o` is {`sbase_i`[7:3], 3'd7}, and lower line 2 is cleared.
- R9: When the lower resolver has nothing pending at an acknowledge, `vec_o` is {`mbase_i`[7:3], 3'd7}, and no pending state changes.
- R10: After an upper-group acknowledge, lower line 2 is latched again in the same edge if the upper resolver still has requests pending. `int_o` then stays 1.
- R11: If a new rising edge arrives on an edge-mode line in the same cycle that its acknowledge clears it, the line stays pending.
- R12: While `rst_n` is 0 at a clock edge, all pending and edge history is cleared, and `int_o` and `vec_vld_o` are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 16 | Request lines; bit 2 unused (cascade slot) |
| lvl_i | input | 16 | Per-line mode: 1 level, 0 edge |
| ack_i | input | 1 | Processor acknowledge strobe, one cycle |
| mbase_i | input | 8 | Vector base for the lower resolver (bits 7:3 used) |
| sbase_i | input | 8 | Vector base for the upper resolver (bits 7:3 used) |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector number, valid with `vec_vld_o` |
| vec_vld_o | output | 1 | One-cycle strobe marking `vec_o` |

## Verification
Two functions can meet in one edge: the acknowledge that clears a line, and a fresh request edge or upper-group re-latch that sets it again. The directed part provokes this on purpose in two ways. It drops and re-raises an edge line so that the new edge lands on the acknowledge cycle. It also acknowledges the upper group while a second upper request waits. Each case is judged by `int_o` right after that edge and by the vector of the following acknowledge. Random traffic with frequent acknowledges and mixed line modes then makes the same collisions, as well as level drops under a latched line 2. Every cycle is compared with a bench model built from the requirements.

// File: rtl/irq_cascade_pkg.sv
// Package: shared constants and the acknowledge routing type for the
// cascaded interrupt resolver. Assumes 8-line resolvers by default.
package irq_cascade_pkg;

    localparam int CORE_LINES   = 8;   // request lines per resolver
    localparam int CASC_DEFAULT = 2;   // lower-resolver line fed by the upper group
    localparam int VEC_WIDTH    = 8;   // width of the returned vector

    // Which source answers an acknowledge
    typedef enum logic [1:0] {
        RT_MASTER      = 2'd0,
        RT_SLAVE       = 2'd1,
        RT_SLAVE_SPUR  = 2'd2,
        RT_MASTER_SPUR = 2'd3
    } ack_route_e;

endpackage

// File: rtl/irq_prio_pick.sv
// Module: irq_prio_pick
// Fixed-priority picker: reports whether any input bit is set and the index
// of the lowest set bit. Purely combinational; assumes LINES is a power of two.
module irq_prio_pick #(
    parameter  int LINES = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] req_i,
    output logic             vld_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top so the lowest set bit is the last one written
    always_comb begin
        vld_o = |req_i;
        idx_o = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_line_core.sv
// Module: irq_line_core
// One resolver of LINES request lines. It keeps the pending bits and the edge
// history, applies acknowledge clears, and names the winning line. When
// CASC_EN is set, line CASC_LINE ignores its request pin. It is latched
// instead by casc_i, a one-shot mark with no edge history. Assumes ack_i is
// only raised for a line that is currently pending.
module irq_line_core #(
    parameter  int LINES     = 8,
    parameter  bit CASC_EN   = 1'b0,
    parameter  int CASC_LINE = 2,
    localparam int IDX_W     = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_i,
    input  logic [LINES-1:0] lvl_i,
    input  logic             ack_i,
    input  logic [IDX_W-1:0] ack_idx_i,
    input  logic             casc_i,
    output logic             any_nx_o,
    output logic             win_vld_o,
    output logic [IDX_W-1:0] win_idx_o
);

    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] pend_q;
    logic [LINES-1:0] pend_d;
    logic [LINES-1:0] hit;

    // Decode the acknowledge into a one-hot clear mask
    always_comb begin
        hit = ack_i ? (LINES'(1) << ack_idx_i) : '0;
    end

    // Next pending value, line by line
    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        if (CASC_EN && (gi == CASC_LINE)) begin : g_casc
            logic casc_unused;
            assign casc_unused = req_i[gi] ^ lvl_i[gi] ^ prev_q[gi];
            assign pend_d[gi]  = (pend_q[gi] & ~hit[gi]) | casc_i;
        end else begin : g_req
            assign pend_d[gi] = lvl_i[gi] ? req_i[gi]
                              : ((pend_q[gi] & ~hit[gi]) | (req_i[gi] & ~prev_q[gi]));
        end
    end

    if (!CASC_EN) begin : g_nocasc
        logic casc_in_unused;
        assign casc_in_unused = casc_i;
    end

    // Pending and edge-history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= req_i;
            pend_q <= pend_d;
        end
    end

    assign any_nx_o = |pend_d;

    irq_prio_pick #(.LINES(LINES)) u_pick (
        .req_i (pend_q),
        .vld_o (win_vld_o),
        .idx_o (win_idx_o)
    );

endmodule

// File: rtl/irq_vec_sel.sv
// Module: irq_vec_sel
// Acknowledge decoder: from the two winners it picks which resolvers to clear
// and forms the vector. The upper bits come from the answering base and the
// low bits from the line, or all ones when nothing is pending. Combinational.
module irq_vec_sel
    import irq_cascade_pkg::*;
#(
    parameter  int LINES     = 8,
    parameter  int CASC_LINE = 2,
    parameter  int VEC_W     = 8,
    localparam int IDX_W     = $clog2(LINES)
) (
    input  logic             ack_i,
    input  logic             m_vld_i,
    input  logic [IDX_W-1:0] m_idx_i,
    input  logic             s_vld_i,
    input  logic [IDX_W-1:0] s_idx_i,
    input  logic [VEC_W-1:0] mbase_i,
    input  logic [VEC_W-1:0] sbase_i,
    output logic             m_ack_o,
    output logic             s_ack_o,
    output logic [VEC_W-1:0] vec_o
);

    localparam logic [IDX_W-1:0] SPUR_IDX = '1;
    localparam logic [IDX_W-1:0] CASC_IDX = IDX_W'(CASC_LINE);

    ack_route_e route;

    // Choose the answering source
    always_comb begin
        if (!m_vld_i)                 route = RT_MASTER_SPUR;
        else if (m_idx_i != CASC_IDX) route = RT_MASTER;
        else if (s_vld_i)             route = RT_SLAVE;
        else                          route = RT_SLAVE_SPUR;
    end

    // Clear commands and vector for the chosen source
    always_comb begin
        m_ack_o = ack_i & m_vld_i;
        s_ack_o = ack_i & (route == RT_SLAVE);
        unique case (route)
            RT_MASTER:     vec_o = {mbase_i[VEC_W-1:IDX_W], m_idx_i};
            RT_SLAVE:      vec_o = {sbase_i[VEC_W-1:IDX_W], s_idx_i};
            RT_SLAVE_SPUR: vec_o = {sbase_i[VEC_W-1:IDX_W], SPUR_IDX};
            default:       vec_o = {mbase_i[VEC_W-1:IDX_W], SPUR_IDX};
        endcase
    end

endmodule

// File: rtl/irq_cascade_ack.sv
// Module: irq_cascade_ack
// Top: two resolvers with the upper group chained into lower line CASC_LINE.
// The processor sees int_o. A one-cycle ack_i is answered one cycle later by
// vec_o with vec_vld_o. Assumes ack_i is a single-cycle strobe.
module irq_cascade_ack
    import irq_cascade_pkg::*;
#(
    parameter  int LINES     = CORE_LINES,
    parameter  int CASC_LINE = CASC_DEFAULT,
    parameter  int VEC_W     = VEC_WIDTH,
    localparam int IDX_W     = $clog2(LINES),
    localparam int TOTAL     = 2 * LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOTAL-1:0] req_i,
    input  logic [TOTAL-1:0] lvl_i,
    input  logic             ack_i,
    input  logic [VEC_W-1:0] mbase_i,
    input  logic [VEC_W-1:0] sbase_i,
    output logic             int_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_vld_o
);

    logic             m_vld, s_vld;
    logic [IDX_W-1:0] m_idx, s_idx;
    logic             m_ack, s_ack;
    logic             s_any_nx;
    logic             m_any_nx_unused;
    logic [VEC_W-1:0] vec_d;
    logic [VEC_W-1:0] vec_q;
    logic             vld_q;

    // Lower resolver, talks to the processor
    irq_line_core #(.LINES(LINES), .CASC_EN(1'b1), .CASC_LINE(CASC_LINE)) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i[LINES-1:0]),
        .lvl_i     (lvl_i[LINES-1:0]),
        .ack_i     (m_ack),
        .ack_idx_i (m_idx),
        .casc_i    (s_any_nx),
        .any_nx_o  (m_any_nx_unused),
        .win_vld_o (m_vld),
        .win_idx_o (m_idx)
    );

    // Upper resolver, chained into the lower one
    irq_line_core #(.LINES(LINES), .CASC_EN(1'b0), .CASC_LINE(CASC_LINE)) u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i[TOTAL-1:LINES]),
        .lvl_i     (lvl_i[TOTAL-1:LINES]),
        .ack_i     (s_ack),
        .ack_idx_i (s_idx),
        .casc_i    (1'b0),
        .any_nx_o  (s_any_nx),
        .win_vld_o (s_vld),
        .win_idx_o (s_idx)
    );

    irq_vec_sel #(.LINES(LINES), .CASC_LINE(CASC_LINE), .VEC_W(VEC_W)) u_sel (
        .ack_i   (ack_i),
        .m_vld_i (m_vld),
        .m_idx_i (m_idx),
        .s_vld_i (s_vld),
        .s_idx_i (s_idx),
        .mbase_i (mbase_i),
        .sbase_i (sbase_i),
        .m_ack_o (m_ack),
        .s_ack_o (s_ack),
        .vec_o   (vec_d)
    );

    // Register the vector and its one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= ack_i;
            if (ack_i) vec_q <= vec_d;
        end
    end

    assign int_o     = m_vld;
    assign vec_o     = vec_q;
    assign vec_vld_o = vld_q;

endmodule

// File: rtl/irq_cascade_ack_chk.sv
// Module: irq_cascade_ack_chk
// Property checker bound to irq_cascade_ack. It watches the acknowledge
// timing, the vector sources and the cascade-to-interrupt link.
module irq_cascade_ack_chk #(
    parameter int IDX_W = 3,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_i,
    input logic             int_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             vec_vld_o,
    input logic [VEC_W-1:0] mbase_i,
    input logic [VEC_W-1:0] sbase_i,
    input logic             s_any_nx
);

    AST_VLD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> vec_vld_o); // R5

    AST_VLD_ONLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !vec_vld_o); // R5

    AST_MASTER_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !int_o) |=> (vec_o[IDX_W-1:0] == {IDX_W{1'b1}}
            && vec_o[VEC_W-1:IDX_W] == $past(mbase_i[VEC_W-1:IDX_W]))); // R9

    AST_CASC_RAISES_INT: assert property (@(posedge clk) disable iff (!rst_n)
        s_any_nx |=> int_o); // R6

    AST_VEC_BASE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld_o |-> (vec_o[VEC_W-1:IDX_W] == $past(mbase_i[VEC_W-1:IDX_W])
            || vec_o[VEC_W-1:IDX_W] == $past(sbase_i[VEC_W-1:IDX_W]))); // R7

endmodule

bind irq_cascade_ack irq_cascade_ack_chk #(.IDX_W(IDX_W), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_i     (ack_i),
    .int_o     (int_o),
    .vec_o     (vec_o),
    .vec_vld_o (vec_vld_o),
    .mbase_i   (mbase_i),
    .sbase_i   (sbase_i),
    .s_any_nx  (s_any_nx)
);

// File: tb/irq_cascade_ack_tb_top.sv
// Bench: directed corner cases, then seeded random traffic, all compared
// against a cycle model written from the requirements.
module irq_cascade_ack_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic [15:0] lvl = '0;
    logic        ack = 1'b0;
    logic [7:0]  mbase = 8'h2D;
    logic [7:0]  sbase = 8'h77;
    logic        int_w, vld_w;
    logic [7:0]  vec_w;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [15:0] md_prev = '0;
    logic [15:0] md_pend = '0;
    logic        exp_int = 1'b0;
    logic        exp_vld = 1'b0;
    logic [7:0]  exp_vec = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cascade_ack dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .lvl_i     (lvl),
        .ack_i     (ack),
        .mbase_i   (mbase),
        .sbase_i   (sbase),
        .int_o     (int_w),
        .vec_o     (vec_w),
        .vec_vld_o (vld_w)
    );

    function automatic int lowest8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one edge with the current inputs
    task automatic model_step();
        int mw, sw;
        logic [15:0] clr, nxt;
        mw = lowest8(md_pend[7:0]);
        sw = lowest8(md_pend[15:8]);
        clr = '0;
        exp_vld = ack;
        if (ack) begin
            if (mw == 8) exp_vec = {mbase[7:3], 3'd7};
            else if (mw == 2) begin
                clr[2] = 1'b1;
                if (sw == 8) exp_vec = {sbase[7:3], 3'd7};
                else begin
                    exp_vec = {sbase[7:3], 3'(sw)};
                    clr[8 + sw] = 1'b1;
                end
            end else begin
                clr[mw] = 1'b1;
                exp_vec = {mbase[7:3], 3'(mw)};
            end
        end
        nxt = '0;
        for (int i = 0; i < 16; i++) begin
            if (i != 2) begin
                if (lvl[i]) nxt[i] = req[i];
                else nxt[i] = (md_pend[i] & ~clr[i]) | (req[i] & ~md_prev[i]);
            end
        end
        nxt[2] = (md_pend[2] & ~clr[2]) | (|nxt[15:8]);
        md_pend = nxt;
        md_prev = req;
        exp_int = |nxt[7:0];
    endtask

    // One clock with optional acknowledge, then compare outputs
    task automatic cycle(input logic a, input string tag);
        ack = a;
        model_step();
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
        chk({tag, " int"}, 32'(int_w), 32'(exp_int));
        chk({tag, " vld"}, 32'(vld_w), 32'(exp_vld));
        if (exp_vld) chk({tag, " vec"}, 32'(vec_w), 32'(exp_vec));
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        chk("R12 int in reset", 32'(int_w), 32'h0);
        chk("R12 vld in reset", 32'(vld_w), 32'h0);
        rst_n = 1'b1;
        cycle(1'b0, "R12 after reset");

        // R1 R4 R5 R9: edge line 5
        req[5] = 1'b1;
        cycle(1'b0, "R4 edge raises int");
        cycle(1'b1, "R5 ack line 5");
        chk("R5 literal vec", 32'(vec_w), 32'h2D);
        cycle(1'b1, "R1 held high no relatch");
        chk("R9 spurious literal", 32'(vec_w), 32'h2F);
        req[5] = 1'b0;
        cycle(1'b0, "R1 release");

        // R3: lowest line first
        req[6] = 1'b1; req[3] = 1'b1;
        cycle(1'b0, "R3 setup");
        cycle(1'b1, "R3 first");
        chk("R3 first literal", 32'(vec_w), 32'h2B);
        cycle(1'b1, "R3 second");
        chk("R3 second literal", 32'(vec_w), 32'h2E);
        req[6] = 1'b0; req[3] = 1'b0;
        cycle(1'b0, "R3 release");

        // R6: input bit 2 ignored in both modes
        req[2] = 1'b1; lvl[2] = 1'b1;
        cycle(1'b0, "R6 line2 level ignored");
        chk("R6 int stays low", 32'(int_w), 32'h0);
        lvl[2] = 1'b0; req[2] = 1'b0;
        cycle(1'b0, "R6 line2 fall");
        req[2] = 1'b1;
        cycle(1'b1, "R6 line2 edge ignored");
        chk("R6 spurious literal", 32'(vec_w), 32'h2F);
        req[2] = 1'b0;
        cycle(1'b0, "R6 release");

        // R6 R7: upper line 12
        req[12] = 1'b1;
        cycle(1'b0, "R6 cascade raises int");
        cycle(1'b1, "R7 slave vector");
        chk("R7 literal", 32'(vec_w), 32'h74);
        req[12] = 1'b0;
        cycle(1'b0, "R7 release");

        // R10: two upper lines, re-latch of line 2 on the ack edge
        req[9] = 1'b1; req[14] = 1'b1;
        cycle(1'b0, "R10 setup");
        cycle(1'b1, "R10 first");
        chk("R10 first literal", 32'(vec_w), 32'h71);
        chk("R10 int held", 32'(int_w), 32'h1);
        cycle(1'b1, "R10 second");
        chk("R10 second literal", 32'(vec_w), 32'h76);
        req[9] = 1'b0; req[14] = 1'b0;
        cycle(1'b0, "R10 release");

        // R8: level upper line drops under a latched line 2
        lvl[11] = 1'b1; req[11] = 1'b1;
        cycle(1'b0, "R8 setup");
        req[11] = 1'b0;
        cycle(1'b0, "R8 level dropped");
        cycle(1'b1, "R8 slave spurious");
        chk("R8 literal", 32'(vec_w), 32'h77);
        chk("R8 int cleared", 32'(int_w), 32'h0);
        lvl[11] = 1'b0;

        // R2: level lower line survives acknowledge
        lvl[4] = 1'b1; req[4] = 1'b1;
        cycle(1'b0, "R2 setup");
        cycle(1'b1, "R2 first ack");
        chk("R2 literal", 32'(vec_w), 32'h2C);
        chk("R2 still pending", 32'(int_w), 32'h1);
        cycle(1'b1, "R2 second ack");
        req[4] = 1'b0;
        cycle(1'b0, "R2 level drop");
        chk("R2 int low", 32'(int_w), 32'h0);
        lvl[4] = 1'b0;

        // R11: new edge in the same cycle as the clearing ack
        req[6] = 1'b1;
        cycle(1'b0, "R11 setup");
        req[6] = 1'b0;
        cycle(1'b0, "R11 low");
        req[6] = 1'b1;
        cycle(1'b1, "R11 collide");
        chk("R11 still pending", 32'(int_w), 32'h1);
        cycle(1'b1, "R11 second serve");
        chk("R11 literal", 32'(vec_w), 32'h2E);
        req[6] = 1'b0;
        cycle(1'b0, "R11 release");

        // R3: lower line 1 beats the cascade slot
        req[1] = 1'b1; req[8] = 1'b1;
        cycle(1'b0, "R3 cascade setup");
        cycle(1'b1, "R3 line1 before cascade");
        chk("R3 line1 literal", 32'(vec_w), 32'h29);
        cycle(1'b1, "R3 cascade after");
        chk("R3 cascade literal", 32'(vec_w), 32'h70);
        req[1] = 1'b0; req[8] = 1'b0;
        cycle(1'b0, "R3 release");

        // Random traffic
        for (int blk = 0; blk < 6; blk++) begin
            lvl   = 16'($urandom);
            mbase = 8'($urandom);
            sbase = 8'($urandom);
            for (int n = 0; n < 500; n++) begin
                req = req ^ 16'($urandom & $urandom & $urandom);
                cycle(($urandom % 3) == 0, "R4 R5 random");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule